// File: doc/BRIEF.md
# RTC Interrupt Status Register

This block holds the pending-interrupt state of a real-time clock. Three event sources feed it: a periodic tick, an alarm match and the end of a time update. Each arrives as a one-cycle pulse, and the pulse sets a sticky flag for its source. A separate control byte holds one enable bit per source, plus five mode bits that this block only stores and hands on to the rest of the clock.

Software sees two byte-wide locations on a simple bus. Address 0 is the status byte and address 1 is the control byte. Reading the status byte returns every flag together with a summary bit, and the same read clears all the flags. The summary bit and the `irq` output are high while at least one flag is set whose enable is also set. Flags are recorded whatever their enables say, so a driver that polls with interrupts off still sees its events.

Top module: `rtc_irq_status`

## Requirements
- R1: Reset leaves all flags clear, the control byte at 0x00, `bus_rdata` at 0x00 and `irq` low.
- R2: A pulse on `evt_periodic`, `evt_alarm` or `evt_update` sets its flag at the next clock edge, whatever the enables hold. The status byte shows the periodic flag at bit 6, the alarm flag at bit 5 and the update flag at bit 4.
- R3: A read (`bus_rd`=1) at address 0 places the status byte on `bus_rdata` one cycle later. At the same edge it clears every flag.
- R4: Bits 3..0 of the status byte always read 0. A write to address 0 changes neither the flags nor the control byte.
- R5: A write at address 1 stores all 8 bits of `bus_wdata` in the control byte. The stored byte appears on `ctrl_byte`, and a read at address 1 returns it on `bus_rdata` one cycle later. Bit 6 enables the periodic source, bit 5 the alarm source and bit 4 the update source.
- R6: `irq` and status bit 7 are 1 exactly when some flag and its enable are both set.
- R7: When an event pulse coincides with a clearing read, the read returns the flags as they stood before that edge, and that event's flag is set afterwards.
- R8: Control bits 7 and 3..0 do not affect the flags or `irq`.
- R9: A read at address 1 does not clear any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 selects the status byte, 1 selects the control byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| irq | output | 1 | Active-high interrupt request |
| ctrl_byte | output | 8 | Stored control byte |

## Verification
Every result is due one clock edge after its cause:
- A flag and `irq` follow an event pulse at the edge that samples the pulse.
- `bus_rdata` and the flag clearing follow a read at the edge that samples the read.
- `ctrl_byte` follows a write at the edge that samples the write.

The bench drives inputs on the falling edge and advances its own model at the rising edge. It compares `bus_rdata`, `irq` and `ctrl_byte` 2 ns after that rising edge, so each comparison lands in the first cycle where the new value is due.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    // Number of interrupt sources. Index 0 is update, 1 is alarm, 2 is periodic.
    localparam int NUM_SRC  = 3;
    // Bit position of the lowest flag (and of the matching enable).
    localparam int FLAG_LSB = 4;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CTRL   = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/rtc_irq_flag_cell.sv
module rtc_irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // A set wins over a clear, so an event that coincides with a clearing
    // read is kept for the next read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_irq_ctrl_reg.sv
module rtc_irq_ctrl_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] ctrl_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o <= '0;
        end else if (wr_en_i) begin
            ctrl_o <= wdata_i;
        end
    end
endmodule

// File: rtl/rtc_irq_summary.sv
module rtc_irq_summary #(
    parameter int NUM_SRC = 3
) (
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [NUM_SRC-1:0] enables_i,
    output logic               any_o
);
    always_comb begin
        any_o = |(flags_i & enables_i);
    end
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
    import rtc_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    output logic              irq,
    output logic [DATA_W-1:0] ctrl_byte
);
    localparam int FLAG_MSB = FLAG_LSB + NUM_SRC - 1;
    localparam int SUM_BIT  = DATA_W - 1;

    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] flag_q;
    logic [DATA_W-1:0]  ctrl_q;
    logic [DATA_W-1:0]  status_byte;
    logic               any_pending;
    logic               clr_all;
    logic               ctrl_wr;

    assign evt_vec = {evt_periodic, evt_alarm, evt_update};
    assign clr_all = bus_rd && (bus_addr == SEL_STATUS);
    assign ctrl_wr = bus_wr && (bus_addr == SEL_CTRL);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
        rtc_irq_flag_cell flag_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (evt_vec[g]),
            .clr_i  (clr_all),
            .flag_o (flag_q[g])
        );
    end

    rtc_irq_ctrl_reg #(.DATA_W(DATA_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (ctrl_wr),
        .wdata_i (bus_wdata),
        .ctrl_o  (ctrl_q)
    );

    rtc_irq_summary #(.NUM_SRC(NUM_SRC)) sum_i (
        .flags_i   (flag_q),
        .enables_i (ctrl_q[FLAG_MSB:FLAG_LSB]),
        .any_o     (any_pending)
    );

    always_comb begin
        status_byte                    = '0;
        status_byte[FLAG_MSB:FLAG_LSB] = flag_q;
        status_byte[SUM_BIT]           = any_pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= (bus_addr == SEL_CTRL) ? ctrl_q : status_byte;
        end
    end

    assign irq       = any_pending;
    assign ctrl_byte = ctrl_q;

endmodule

// File: rtl/rtc_irq_status_chk.sv
module rtc_irq_status_chk #(
    parameter int NUM_SRC = 3,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_addr,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] evts,
    input logic [NUM_SRC-1:0] flags,
    input logic               irq
);
    // R2: an event pulse always sets its flag
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
            evts[g] |=> flags[g]);
        // R7: an event coinciding with a clearing read survives
        a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !bus_addr && evts[g]) |=> flags[g]);
    end

    // R3: a clearing read with no event leaves every flag clear
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr && evts == '0) |=> (flags == '0));

    // R4: the low nibble of a status read is zero
    a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr) |=> (bus_rdata[3:0] == 4'h0));

    // R6: no pending flag means no interrupt
    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq);

    // R9: reading control, writing, or idling leaves the flags alone
    a_r9_ctrl_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_rd && !bus_addr) && evts == '0) |=> $stable(flags));

    // R4: a write never touches the flags
    a_r4_write_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && evts == '0) |=> $stable(flags));
endmodule

bind rtc_irq_status rtc_irq_status_chk #(.NUM_SRC(rtc_irq_pkg::NUM_SRC), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .evts      (evt_vec),
    .flags     (flag_q),
    .irq       (irq)
);

// File: tb/rtc_irq_status_tb.sv
module rtc_irq_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       evt_periodic = 1'b0;
    logic       evt_alarm = 1'b0;
    logic       evt_update = 1'b0;
    logic       irq;
    logic [7:0] ctrl_byte;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    // Bench model, built from the requirements.
    logic [2:0] m_flags = 3'b000;   // bit2 periodic, bit1 alarm, bit0 update
    logic [7:0] m_ctrl  = 8'h00;
    logic [7:0] m_rdata = 8'h00;

    always #4 clk = ~clk;   // 125 MHz

    rtc_irq_status dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .evt_periodic (evt_periodic),
        .evt_alarm    (evt_alarm),
        .evt_update   (evt_update),
        .irq          (irq),
        .ctrl_byte    (ctrl_byte)
    );

    // Status byte per R2, R4 and R6.
    function automatic logic [7:0] status_of(input logic [2:0] f, input logic [7:0] c);
        return {|(f & c[6:4]), f, 4'b0000};
    endfunction

    function automatic logic irq_of(input logic [2:0] f, input logic [7:0] c);
        return |(f & c[6:4]);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic a, input logic rd,
                        input logic wr, input logic [7:0] wd, input logic [2:0] ev);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        {evt_periodic, evt_alarm, evt_update} = ev;
        @(posedge clk);
        if (rd) m_rdata = a ? m_ctrl : status_of(m_flags, m_ctrl);
        m_flags = ev | ((rd && !a) ? 3'b000 : m_flags);
        if (wr && a) m_ctrl = wd;
        #2;
        check(tag, "rdata", bus_rdata, m_rdata);
        check(tag, "irq", {7'b0, irq}, {7'b0, irq_of(m_flags, m_ctrl)});
        check(tag, "ctrl_byte", ctrl_byte, m_ctrl);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        {evt_periodic, evt_alarm, evt_update} = 3'b000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "rdata", bus_rdata, 8'h00);
        check("R1", "irq", {7'b0, irq}, 8'h00);
        check("R1", "ctrl_byte", ctrl_byte, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 1'b0, 1'b1, 1'b0, 8'h00, 3'b000);

        // R5: control byte write and readback
        step("R5", 1'b1, 1'b0, 1'b1, 8'hA5, 3'b000);
        step("R5", 1'b1, 1'b1, 1'b0, 8'h00, 3'b000);
        step("R5", 1'b1, 1'b0, 1'b1, 8'h00, 3'b000);

        // R2: a flag sets with its enable off, then R3 clears it
        step("R2", 1'b0, 1'b0, 1'b0, 8'h00, 3'b100);
        step("R2", 1'b0, 1'b1, 1'b0, 8'h00, 3'b000);
        step("R3", 1'b0, 1'b1, 1'b0, 8'h00, 3'b000);
        step("R2", 1'b0, 1'b0, 1'b0, 8'h00, 3'b011);
        step("R2", 1'b0, 1'b1, 1'b0, 8'h00, 3'b000);

        // R6: an enabled alarm raises irq, and a read drops it
        step("R6", 1'b1, 1'b0, 1'b1, 8'h20, 3'b000);
        step("R6", 1'b0, 1'b0, 1'b0, 8'h00, 3'b010);
        step("R6", 1'b0, 1'b0, 1'b0, 8'h00, 3'b000);
        step("R6", 1'b0, 1'b1, 1'b0, 8'h00, 3'b000);

        // R7: an event coinciding with a clearing read
        step("R7", 1'b1, 1'b0, 1'b1, 8'h10, 3'b000);
        step("R7", 1'b0, 1'b0, 1'b0, 8'h00, 3'b100);
        step("R7", 1'b0, 1'b1, 1'b0, 8'h00, 3'b001);
        step("R7", 1'b0, 1'b1, 1'b0, 8'h00, 3'b000);

        // R4: a status write is ignored and the low nibble stays zero
        step("R4", 1'b0, 1'b0, 1'b0, 8'h00, 3'b110);
        step("R4", 1'b0, 1'b0, 1'b1, 8'hFF, 3'b000);
        step("R4", 1'b0, 1'b1, 1'b0, 8'h00, 3'b000);

        // R8: mode bits without enables leave irq low
        step("R8", 1'b1, 1'b0, 1'b1, 8'h8F, 3'b000);
        step("R8", 1'b0, 1'b0, 1'b0, 8'h00, 3'b111);
        step("R8", 1'b0, 1'b0, 1'b0, 8'h00, 3'b000);

        // R9: a control read keeps the flags
        step("R9", 1'b1, 1'b1, 1'b0, 8'h00, 3'b000);
        step("R9", 1'b0, 1'b1, 1'b0, 8'h00, 3'b000);

        // Random traffic covering R2, R3, R5, R6 and R7 together
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] ev;
            logic a, rd, wr;
            ev[0] = ($urandom % 6) == 0;
            ev[1] = ($urandom % 7) == 0;
            ev[2] = ($urandom % 5) == 0;
            a  = $urandom % 2;
            rd = ($urandom % 3) == 0;
            wr = ($urandom % 8) == 0;
            step("R6 random", a, rd, wr, 8'($urandom), ev);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule